// File: doc/BRIEF.md
# Host Interrupt Aggregator with Dual Status Views

This block gathers a bank of device interrupt sources into one sticky status register and drives a single level interrupt line toward the host. Each source reports with a one-cycle event pulse; the matching status bit then stays set until the host clears it. A status bit reaches the host line only while its mask bit is 0.

The host reaches the block through a small register bus with address, write enable, read enable, write data and registered read data. Status can be read in two ways: a peek view that leaves status unchanged, and a take view that returns status and clears all of it. Status bits can also be cleared one by one through a write-one acknowledge register. The mask can be written whole, or changed bit by bit through set and clear aliases. The default source map is: rx buffer 0 data (bit 0), tx data (1), tx transfer (2), rx buffer 1 data (3), rx transfer (4), event mailbox (5, 6), wake (7), debug trace (8, 9), command complete (10) and init complete (14).

Top module: `hint_aggregator`

## Requirements
- R1: After reset, status is 0, the mask is 0x0001 (only source 0 blocked), read data is 0 and the host line is deasserted.
- R2: A one-cycle pulse on source i sets status bit i at the next clock edge, and the bit stays set until it is cleared.
- R3: Address 0 is the mask register: a write replaces the whole mask and a read returns it.
- R4: A write to address 1 sets every mask bit written as 1 and leaves the other mask bits unchanged.
- R5: A write to address 2 clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status and clears every status bit.
- R8: A write to address 5 clears each status bit written as 1; bits written as 0 are untouched, and the result is seen in both status views.
- R9: When a source pulses in the same cycle as a clear of its bit (acknowledge or take), the bit ends set.
- R10: The host line is asserted when any status bit with mask bit 0 is set; with irq_active_low at 0 asserted means 1, with it at 1 asserted means 0.
- R11: Mask writes never change status, and the host line follows a mask change right after the writing clock edge.
- R12: Read data is registered: it changes at the clock edge where read enable is high and holds otherwise; addresses 1, 2, 5, 6 and 7 and bits above the source count read 0, and writes to addresses 3, 4, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | One-cycle event pulses, one per source |
| reg_addr | input | ADDR_W | Register address |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_active_low | input | 1 | Selects an active-low host line when 1 |
| host_irq | output | 1 | Level host interrupt |

## Verification
The bench builds the block with its defaults: 16 sources, a 32-bit bus and a 3-bit address, so all eight addresses, including the unused ones, are reachable. The zero upper half of the read data is checked on every read. The 0x0001 reset mask makes the blocked-source case visible right after reset. Directed sequences cover the alias writes, the two status views and the same-cycle set-versus-clear races. A random phase then drives all addresses, both polarities and overlapping events against a reference model.

// File: rtl/hint_pkg.sv
package hint_pkg;
   // register map (decoded by the top)
   localparam int unsigned ADR_MASK = 0;
   localparam int unsigned ADR_MSET = 1;
   localparam int unsigned ADR_MCLR = 2;
   localparam int unsigned ADR_PEEK = 3;
   localparam int unsigned ADR_TAKE = 4;
   localparam int unsigned ADR_ACK  = 5;

   // default source positions
   localparam int unsigned SRC_RX0_DATA  = 0;
   localparam int unsigned SRC_TX_DATA   = 1;
   localparam int unsigned SRC_TX_XFER   = 2;
   localparam int unsigned SRC_RX1_DATA  = 3;
   localparam int unsigned SRC_RX_XFER   = 4;
   localparam int unsigned SRC_MBOX_A    = 5;
   localparam int unsigned SRC_MBOX_B    = 6;
   localparam int unsigned SRC_WAKE      = 7;
   localparam int unsigned SRC_TRACE_A   = 8;
   localparam int unsigned SRC_TRACE_B   = 9;
   localparam int unsigned SRC_CMD_DONE  = 10;
   localparam int unsigned SRC_INIT_DONE = 14;

   typedef struct packed {
      logic mask_wr;
      logic mask_set;
      logic mask_clr;
      logic ack_wr;
      logic take_rd;
   } hint_strobe_t;
endpackage

// File: rtl/hint_status_bank.sv
module hint_status_bank #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic               ack_wr,
   input  logic [NUM_SRC-1:0] ack_bits,
   input  logic               take,
   output logic [NUM_SRC-1:0] status
);
   logic [NUM_SRC-1:0] clr_vec;

   always_comb begin
      clr_vec = '0;
      if (ack_wr) clr_vec = clr_vec | ack_bits;
      if (take)   clr_vec = '1;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          status[i] <= 1'b0;
         else if (evt[i])     status[i] <= 1'b1;
         else if (clr_vec[i]) status[i] <= 1'b0;
      end
   end

   a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (status & $past(evt)) == $past(evt));
   a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> status == $past(evt));
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && !take |=> (status & $past(ack_bits & ~evt)) == '0);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !take && !ack_wr && evt == '0 |=> $stable(status));
endmodule

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
   parameter int unsigned NUM_SRC = 16,
   parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_full,
   input  logic               wr_set,
   input  logic               wr_clr,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                  mask[i] <= MASK_RST[i];
         else if (wr_full)            mask[i] <= wbits[i];
         else if (wr_set && wbits[i]) mask[i] <= 1'b1;
         else if (wr_clr && wbits[i]) mask[i] <= 1'b0;
      end
   end

   a_r3_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full |=> mask == $past(wbits));
   a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set && !wr_full |=> mask == ($past(mask) | $past(wbits)));
   a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr && !wr_full |=> mask == ($past(mask) & ~$past(wbits)));
   a_r11_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_full && !wr_set && !wr_clr |=> $stable(mask));
endmodule

// File: rtl/hint_read_mux.sv
module hint_read_mux #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_SRC-1:0] status,
   output logic [DATA_W-1:0]  rdata
);
   import hint_pkg::*;
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == ADDR_W'(ADR_MASK))
         sel = DATA_W'(mask);
      else if (addr == ADDR_W'(ADR_PEEK) || addr == ADDR_W'(ADR_TAKE))
         sel = DATA_W'(status);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel;
   end

   a_r6_peek_value: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr == ADDR_W'(ADR_PEEK) |=> rdata == DATA_W'($past(status)));
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   a_r12_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && addr > ADDR_W'(ADR_ACK) |=> rdata == '0);
endmodule

// File: rtl/hint_aggregator.sv
module hint_aggregator #(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 3,
   parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr_en,
   input  logic               reg_rd_en,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               irq_active_low,
   output logic               host_irq
);
   import hint_pkg::*;

   if (NUM_SRC > DATA_W) begin : g_bad_width
      $error("hint_aggregator: NUM_SRC must not exceed DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("hint_aggregator: ADDR_W must be at least 3");
   end

   hint_strobe_t       stb;
   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] mask;
   logic               pending;

   assign wbits = reg_wdata[NUM_SRC-1:0];

   always_comb begin
      stb          = '0;
      stb.mask_wr  = reg_wr_en && reg_addr == ADDR_W'(ADR_MASK);
      stb.mask_set = reg_wr_en && reg_addr == ADDR_W'(ADR_MSET);
      stb.mask_clr = reg_wr_en && reg_addr == ADDR_W'(ADR_MCLR);
      stb.ack_wr   = reg_wr_en && reg_addr == ADDR_W'(ADR_ACK);
      stb.take_rd  = reg_rd_en && reg_addr == ADDR_W'(ADR_TAKE);
   end

   hint_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (src_evt),
      .ack_wr   (stb.ack_wr),
      .ack_bits (wbits),
      .take     (stb.take_rd),
      .status   (status)
   );

   hint_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_full (stb.mask_wr),
      .wr_set  (stb.mask_set),
      .wr_clr  (stb.mask_clr),
      .wbits   (wbits),
      .mask    (mask)
   );

   hint_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (reg_rd_en),
      .addr   (reg_addr),
      .mask   (mask),
      .status (status),
      .rdata  (reg_rdata)
   );

   assign pending  = |(status & ~mask);
   assign host_irq = pending ^ irq_active_low;

   a_r12_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stb.mask_wr, stb.mask_set, stb.mask_clr, stb.ack_wr}));
   a_r11_status_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.mask_wr || stb.mask_set || stb.mask_clr) && src_evt == '0 && !stb.take_rd
      |=> $stable(status));
   a_r12_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en && reg_addr >= ADDR_W'(ADR_PEEK) && reg_addr != ADDR_W'(ADR_ACK)
      && !reg_rd_en |=> $stable(mask));
endmodule

// File: tb/hint_aggregator_test.sv
module hint_aggregator_test;
   localparam int PERIOD = 10;
   localparam int NS = 16;
   localparam int DW = 32;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src_evt = '0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr_en = 1'b0;
   logic          reg_rd_en = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq_active_low = 1'b0;
   logic          host_irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 0;

   hint_aggregator #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_active_low(irq_active_low), .host_irq(host_irq)
   );

   always #(PERIOD/2) clk = ~clk;

   // behavioural reference model
   int unsigned m_status, m_mask, m_rd;
   always @(posedge clk) begin
      int unsigned st, mk, clr;
      if (!rst_n) begin
         m_status <= 0; m_mask <= 1; m_rd <= 0;
      end else begin
         st = m_status; mk = m_mask; clr = 0;
         if (reg_rd_en) begin
            case (reg_addr)
               0: m_rd <= mk;
               3, 4: m_rd <= st;
               default: m_rd <= 0;
            endcase
            if (reg_addr == 4) clr = 32'hFFFF;
         end
         if (reg_wr_en) begin
            case (reg_addr)
               0: mk = reg_wdata & 32'hFFFF;
               1: mk = mk | (reg_wdata & 32'hFFFF);
               2: mk = mk & ~reg_wdata & 32'hFFFF;
               5: clr = clr | (reg_wdata & 32'hFFFF);
               default: ;
            endcase
         end
         m_status <= ((st & ~clr) | src_evt) & 32'hFFFF;
         m_mask   <= mk;
      end
   end

   task automatic check(string req, int unsigned act, int unsigned exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison, a quarter period after the rising edge
   always @(posedge clk) begin
      #(PERIOD/4);
      if (rst_n && !done) begin
         check("R12 rdata vs model", reg_rdata, m_rd);
         check("R10 host_irq vs model", 32'(host_irq),
               32'(((m_status & ~m_mask) != 0) ^ irq_active_low));
      end
   end

   // one bus cycle: drive at falling edge, return read data one edge later
   task automatic op(bit wr, bit rd, int unsigned a, int unsigned wd,
                     int unsigned ev, output int unsigned rdv);
      @(negedge clk);
      reg_wr_en = wr; reg_rd_en = rd; reg_addr = AW'(a);
      reg_wdata = wd; src_evt = NS'(ev);
      @(negedge clk);
      rdv = reg_rdata;
      reg_wr_en = 0; reg_rd_en = 0; src_evt = '0;
   endtask

   task automatic rd(int unsigned a, output int unsigned v);
      op(0, 1, a, 0, 0, v);
   endtask
   task automatic wr(int unsigned a, int unsigned d);
      int unsigned t;
      op(1, 0, a, d, 0, t);
   endtask
   task automatic pulse(int unsigned ev);
      int unsigned t;
      op(0, 0, 0, 0, ev, t);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1;
         n_checks++; n_fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int unsigned v;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 reset rdata", reg_rdata, 0);
      check("R1 reset host_irq", 32'(host_irq), 0);
      rd(0, v);  check("R1 reset mask", v, 32'h0001);
      rd(3, v);  check("R1 reset status", v, 0);

      pulse(32'h0001);
      check("R10 masked source 0 no irq", 32'(host_irq), 0);
      rd(3, v);  check("R2 R6 peek after pulse", v, 32'h0001);
      rd(3, v);  check("R6 peek leaves status", v, 32'h0001);
      pulse(32'h0020);
      check("R10 unmasked source irq", 32'(host_irq), 1);
      check("R2 hold without read", 32'(host_irq), 1);

      wr(1, 32'h0020);
      check("R11 irq follows mask set", 32'(host_irq), 0);
      rd(0, v);  check("R4 mask set alias", v, 32'h0021);
      rd(3, v);  check("R11 status untouched by mask", v, 32'h0021);
      wr(2, 32'h0021);
      rd(0, v);  check("R5 mask clear alias", v, 32'h0000);
      check("R10 irq after clear alias", 32'(host_irq), 1);

      wr(5, 32'h0001);
      rd(3, v);  check("R8 ack clears bit 0", v, 32'h0020);
      wr(5, 32'h0000);
      rd(3, v);  check("R8 ack zero no effect", v, 32'h0020);
      rd(4, v);  check("R7 take returns status", v, 32'h0020);
      rd(3, v);  check("R7 take cleared all", v, 0);
      check("R10 irq drops after take", 32'(host_irq), 0);

      op(0, 1, 4, 0, 32'h0008, v);
      check("R9 take with event returns old", v, 0);
      rd(3, v);  check("R9 event wins over take", v, 32'h0008);
      op(1, 0, 5, 32'h0008, 32'h0008, v);
      rd(3, v);  check("R9 event wins over ack", v, 32'h0008);
      wr(5, 32'h0008);
      rd(3, v);  check("R8 ack seen in peek", v, 0);

      wr(0, 32'hFFFF_FFFF);
      rd(0, v);  check("R3 mask full write readback", v, 32'h0000_FFFF);
      pulse(32'h4400);
      check("R10 all masked no irq", 32'(host_irq), 0);
      irq_active_low = 1;
      @(negedge clk);
      check("R10 active low idle level", 32'(host_irq), 1);
      wr(0, 32'h0000);
      check("R10 active low asserted", 32'(host_irq), 0);
      irq_active_low = 0;

      wr(3, 32'h1234);
      wr(4, 32'hFFFF);
      rd(3, v);  check("R12 writes to read-only ignored", v, 32'h4400);
      rd(0, v);  check("R12 mask untouched by ro write", v, 0);
      rd(6, v);  check("R12 unmapped reads zero", v, 0);
      rd(5, v);  check("R12 ack address reads zero", v, 0);

      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         reg_wr_en = ($urandom % 3) == 0;
         reg_rd_en = ($urandom % 3) == 0;
         reg_addr  = AW'($urandom % 8);
         reg_wdata = $urandom;
         src_evt   = NS'($urandom & $urandom & $urandom);
         if ((k % 97) == 0) irq_active_low = ~irq_active_low;
      end
      @(negedge clk);
      reg_wr_en = 0; reg_rd_en = 0; src_evt = '0;
      repeat (2) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule